// File: doc/BRIEF.md
# Bus-Synchronized Clock Phase Divider

This block derives a half-rate phase signal from a slow bus clock. Its phase is locked to the host CPU's eight-state bus cycle (S0 to S7), so a coprocessor bridge can tell the bus states apart. A free-running divider would start in either of two phases and could not distinguish S1/S5 from S3/S7. This one is held low from reset until the first falling edge of the active-low data acknowledge. The host never returns that acknowledge before S4, so the divider is released there and makes its first toggle on the bus-clock rising edge that opens S6. From then on it is low in S0, S1, S4 and S5 and high in S2, S3, S6 and S7.

Every input is sampled on a fast system clock. The bus clock, the acknowledge and the coprocessor clock each pass through a synchronizer before any edge is detected. The system clock must run at least four times faster than the bus clock. From the synchronized bus clock and the phase signal the block builds three outputs: a combined phase strobe, a preliminary acknowledge strobe, and a triggered acknowledge. The triggered acknowledge is then re-timed to the rising edges of the coprocessor clock to form a size acknowledge. Each even bus state is the high phase of the bus clock and starts on its rising edge. Each odd state is the low phase.

Top module: `busphase_divider`

## Requirements
- R1: While rstN is low, phaseHalf is 0, phaseStrobeN, prelimAckN, trigAckN and sizeAckN are 1, and the block is armed.
- R2: While armed (from reset until the first acknowledge edge), phaseHalf stays 0. prelimAckN is 0 during every low phase of busClk and 1 during every high phase.
- R3: The first falling edge of dtackN after reset releases the divider. After release, phaseHalf toggles on every rising busClk edge. When that edge falls in S4, phaseHalf is 1 in S2, S3, S6 and S7 and 0 in S0, S1, S4 and S5.
- R4: Falling edges of dtackN after release, in any bus state, leave the phaseHalf sequence unchanged.
- R5: phaseStrobeN is the OR of busClk and phaseHalf. After release it is 0 only in S1 and S5.
- R6: prelimAckN is 0 exactly when busClk and phaseHalf are both 0. After release that is S1 and S5.
- R7: trigAckN is 0 only while prelimAckN is active and dtackN is 0. It is 0 in S5 of a cycle acknowledged in S4, and 1 in states where phaseHalf is 1, whatever dtackN does.
- R8: sizeAckN changes only on a rising edge of the synchronized copClk, and takes the trigAckN value present at that edge. It is therefore never asserted before trigAckN and stays 1 through S4 of the acknowledged cycle.
- R9: Driving rstN low at any point, including after release, re-arms the block, and the next acknowledge edge locks the phase again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busClk | input | 1 | Bus clock, asynchronous to clk |
| dtackN | input | 1 | Active-low data acknowledge from the host bus |
| copClk | input | 1 | Coprocessor clock, asynchronous to clk |
| phaseHalf | output | 1 | Half-rate phase signal locked to bus states |
| phaseStrobeN | output | 1 | Combined phase strobe, active low |
| prelimAckN | output | 1 | Preliminary acknowledge strobe, active low |
| trigAckN | output | 1 | Triggered acknowledge, active low |
| sizeAckN | output | 1 | Triggered acknowledge re-timed to copClk, active low |

## Verification
The bus-state model starts at a random state and a random sub-state offset, and reset is released at a random point. The released phase must therefore line up with the states whatever the starting phase of busClk was. The first acknowledge is placed at varying offsets within S4, which shows the release edge is S6 whether the acknowledge lands early or late in that state. A second acknowledge placed in S2, a wrong-phase state, separates a design that re-arms on every acknowledge from one that latches only the first. A reset issued after release shows the arming flag returns. The size acknowledge is sampled in S4, late in S5 and in S7, which separates capture on coprocessor edges from early or missing capture.

// File: rtl/bphase_pkg.sv
`timescale 1ns/1ps
package bphase_pkg;
  // Strobes passed from the control module to the datapath each system cycle.
  typedef struct packed {
    logic busLvl;   // synchronized bus clock level
    logic busRise;  // one-cycle pulse on a synchronized bus clock rising edge
    logic ackLvl;   // synchronized acknowledge level (active low)
    logic copRise;  // one-cycle pulse on a synchronized coprocessor clock rising edge
    logic armed;    // divider held low until the first acknowledge edge
  } phaseCtl_t;
endpackage

// File: rtl/bphase_sync.sv
`timescale 1ns/1ps
module bphase_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES < 2) begin : gBad
      initial $error("bphase_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[LAST-1:0], din};
  end

  assign dout = chain[LAST];
endmodule

// File: rtl/bphase_ctrl.sv
`timescale 1ns/1ps
module bphase_ctrl import bphase_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busClk,
  input  logic      dtackN,
  input  logic      copClk,
  output phaseCtl_t ctl
);
  logic busSync, ackSync, copSync;
  logic busPrev, ackPrev, copPrev;
  logic armed;
  logic ackFall;

  // Idle levels on reset keep any edge from being detected falsely.
  bphase_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uBusSync (
    .clk(clk), .rstN(rstN), .din(busClk), .dout(busSync));
  bphase_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uAckSync (
    .clk(clk), .rstN(rstN), .din(dtackN), .dout(ackSync));
  bphase_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uCopSync (
    .clk(clk), .rstN(rstN), .din(copClk), .dout(copSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPrev <= 1'b1;
      ackPrev <= 1'b1;
      copPrev <= 1'b1;
    end else begin
      busPrev <= busSync;
      ackPrev <= ackSync;
      copPrev <= copSync;
    end
  end

  assign ackFall = ackPrev & ~ackSync;

  // Arming flag: set by reset, cleared once by the first acknowledge edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b1;
    else if (ackFall) armed <= 1'b0;
  end

  always_comb begin
    ctl.busLvl  = busSync;
    ctl.busRise = busSync & ~busPrev;
    ctl.ackLvl  = ackSync;
    ctl.copRise = copSync & ~copPrev;
    ctl.armed   = armed;
  end

  // R3: release happens only on an acknowledge falling edge
  a_r3_release_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> $past(ackFall));

  // R4: once released, only reset can re-arm
  a_r4_stays_released: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !armed);
endmodule

// File: rtl/bphase_datapath.sv
`timescale 1ns/1ps
module bphase_datapath import bphase_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  phaseCtl_t ctl,
  output logic      phaseHalf,
  output logic      phaseStrobeN,
  output logic      prelimAckN,
  output logic      trigAckN,
  output logic      sizeAckN
);
  logic halfNext;
  logic lowWindowN;

  // Held low while armed, otherwise toggles on each bus clock rising edge.
  always_comb begin
    if (ctl.armed)        halfNext = 1'b0;
    else if (ctl.busRise) halfNext = ~phaseHalf;
    else                  halfNext = phaseHalf;
  end

  // Active-low window where both the bus clock and the divider are low.
  assign lowWindowN = ctl.busLvl | halfNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHalf    <= 1'b0;
      phaseStrobeN <= 1'b1;
      prelimAckN   <= 1'b1;
      trigAckN     <= 1'b1;
    end else begin
      phaseHalf    <= halfNext;
      phaseStrobeN <= lowWindowN;
      prelimAckN   <= lowWindowN;
      trigAckN     <= lowWindowN | ctl.ackLvl;
    end
  end

  // Re-time to coprocessor clock rising edges; a missed edge waits for the next.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sizeAckN <= 1'b1;
    else if (ctl.copRise) sizeAckN <= trigAckN;
  end

  // R2: divider held low while armed
  a_r2_held_low: assert property (@(posedge clk) disable iff (!rstN)
    ctl.armed |-> !phaseHalf);

  // R3: toggles on every bus rising edge after release
  a_r3_toggle_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busRise && !ctl.armed) |=> (phaseHalf != $past(phaseHalf)));

  // R3: no change without a bus rising edge
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busRise |=> $stable(phaseHalf));

  // R5: strobe is OR of bus level and divider
  a_r5_strobe_or: assert property (@(posedge clk) disable iff (!rstN)
    phaseStrobeN == ($past(ctl.busLvl) | phaseHalf));

  // R7: triggered acknowledge only inside the preliminary window
  a_r7_trig_in_window: assert property (@(posedge clk) disable iff (!rstN)
    !trigAckN |-> !prelimAckN);

  // R8: size acknowledge moves only on coprocessor rising edges
  a_r8_size_on_cop: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.copRise |=> $stable(sizeAckN));

  // R8: size acknowledge takes the triggered value at the edge
  a_r8_size_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copRise |=> (sizeAckN == $past(trigAckN)));
endmodule

// File: rtl/busphase_divider.sv
`timescale 1ns/1ps
module busphase_divider import bphase_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busClk,
  input  logic dtackN,
  input  logic copClk,
  output logic phaseHalf,
  output logic phaseStrobeN,
  output logic prelimAckN,
  output logic trigAckN,
  output logic sizeAckN
);
  phaseCtl_t ctl;

  bphase_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .dtackN(dtackN),
    .copClk(copClk), .ctl(ctl));

  bphase_datapath uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .phaseHalf(phaseHalf), .phaseStrobeN(phaseStrobeN),
    .prelimAckN(prelimAckN), .trigAckN(trigAckN), .sizeAckN(sizeAckN));
endmodule

// File: tb/tb_busphase_divider.sv
`timescale 1ns/1ps
module tb_busphase_divider;
  localparam int STATE_CLKS = 20;  // system clocks per bus state
  localparam int COP_HALF   = 4;   // system clocks per coprocessor half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0;
  logic dtackN = 1'b1;
  logic copClk = 1'b0;
  logic phaseHalf, phaseStrobeN, prelimAckN, trigAckN, sizeAckN;

  logic [2:0] st;
  int sub;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  busphase_divider dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .dtackN(dtackN), .copClk(copClk),
    .phaseHalf(phaseHalf), .phaseStrobeN(phaseStrobeN), .prelimAckN(prelimAckN),
    .trigAckN(trigAckN), .sizeAckN(sizeAckN));

  // Host bus state model: even states high, odd states low, random start.
  initial begin
    st = 3'($urandom_range(7, 0));
    sub = 0;
    repeat ($urandom_range(STATE_CLKS - 1, 0)) @(negedge clk);
    forever begin
      busClk = ~st[0];
      for (int i = 0; i < STATE_CLKS; i++) begin
        sub = i;
        @(negedge clk);
      end
      st = st + 3'd1;
    end
  end

  initial begin
    repeat ($urandom_range(7, 0)) @(negedge clk);
    forever begin
      copClk = 1'b1;
      repeat (COP_HALF) @(negedge clk);
      copClk = 1'b0;
      repeat (COP_HALF) @(negedge clk);
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    summary();
    $finish;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitAt(input logic [2:0] s, input int b);
    do tick(); while (!(st == s && sub == b));
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s in S%0d: actual %b expected %b", req, what, st, act, exp);
    end
  endtask

  // R1 / R9: reset state, re-arming the divider
  task automatic doReset();
    rstN = 1'b0;
    dtackN = 1'b1;
    repeat ($urandom_range(40, 2)) tick();
    chk("R1", "phaseHalf", phaseHalf, 1'b0);
    chk("R1", "phaseStrobeN", phaseStrobeN, 1'b1);
    chk("R1", "prelimAckN", prelimAckN, 1'b1);
    chk("R1", "trigAckN", trigAckN, 1'b1);
    chk("R1", "sizeAckN", sizeAckN, 1'b1);
    rstN = 1'b1;
  endtask

  // R2: armed phase, prelim follows every bus low phase
  task automatic armedPhase();
    tick();
    for (int k = 0; k < 8; k++) begin
      waitAt(st + 3'd1, 10);
      chk("R2", "phaseHalf armed", phaseHalf, 1'b0);
      chk("R2", "prelimAckN armed", prelimAckN, ~st[0]);
    end
  endtask

  // R3 R5 R6 R7 R8: first acknowledge in S4 at a given offset
  task automatic firstAck(input int offs);
    waitAt(3'd4, offs);
    dtackN = 1'b0;
    waitAt(3'd4, 19);
    chk("R8", "sizeAckN before trig", sizeAckN, 1'b1);
    waitAt(3'd5, 10);
    chk("R3", "phaseHalf S5", phaseHalf, 1'b0);
    chk("R7", "trigAckN S5", trigAckN, 1'b0);
    chk("R5", "phaseStrobeN S5", phaseStrobeN, 1'b0);
    waitAt(3'd5, 17);
    chk("R8", "sizeAckN late S5", sizeAckN, 1'b0);
    waitAt(3'd6, 10);
    chk("R3", "phaseHalf S6 first toggle", phaseHalf, 1'b1);
    chk("R7", "trigAckN S6", trigAckN, 1'b1);
    waitAt(3'd7, 10);
    chk("R8", "sizeAckN S7", sizeAckN, 1'b1);
    chk("R7", "trigAckN S7 ack held", trigAckN, 1'b1);
    waitAt(3'd0, 10);
    dtackN = 1'b1;
  endtask

  // R3 R5 R6: released pattern over whole cycles
  task automatic cyclePattern(input int n);
    waitAt(3'd0, 10);
    for (int c = 0; c < n; c++) begin
      for (int s = 0; s < 8; s++) begin
        if (s != 0) waitAt(3'(s), 10);
        chk("R3", "phaseHalf pattern", phaseHalf, st[1]);
        chk("R5", "phaseStrobeN pattern", phaseStrobeN, !(st == 3'd1 || st == 3'd5));
        chk("R6", "prelimAckN pattern", prelimAckN, !(st == 3'd1 || st == 3'd5));
      end
      waitAt(3'd0, 10);
    end
  endtask

  // R4 R7: acknowledge in a wrong-phase state after release
  task automatic lateAck();
    waitAt(3'd2, 5);
    dtackN = 1'b0;
    waitAt(3'd3, 10);
    chk("R7", "trigAckN S3 wrong phase", trigAckN, 1'b1);
    chk("R4", "phaseHalf S3 after late ack", phaseHalf, 1'b1);
    dtackN = 1'b1;
    cyclePattern(2);
  endtask

  initial begin
    doReset();
    armedPhase();
    firstAck(10);
    cyclePattern(2);
    lateAck();
    // R9: reset after release, then lock at other offsets
    repeat ($urandom_range(100, 1)) tick();
    doReset();
    armedPhase();
    firstAck(1);
    cyclePattern(1);
    repeat ($urandom_range(100, 1)) tick();
    doReset();
    firstAck(17);
    cyclePattern(1);
    summary();
    $finish;
  end
endmodule